// File: doc/BRIEF.md
# MSI capability register file

This block holds the Message Signalled Interrupt capability structure of a PCI function. It sits behind the function's configuration decoder. It claims dword reads and writes that land inside its own window, applies byte enables and per-field write masks, and presents the enable, granted vector count, message address, message data, per-vector mask and pending state to the interrupt logic beside it. Reads are combinational from the stored state. Writes take effect on the next clock edge.

Three parameters fix the shape at elaboration: 64-bit address support, per-vector masking support and the log2 of the vector count the function can use (0 to 5). These choices decide how long the window is and where the data, mask and pending dwords sit. The pending bits cannot be written by software. A hardware port sets and clears them. While the capability is enabled, every write into it also pulses a request to drop the legacy wired interrupt.

Top module: `msi_cap_regs`

## Requirements
- R1: After reset the enable bit, the granted-count field, the address, the data, the mask bits and the pending bits are all zero. Dword 0 reads ID 0x05 in bits 7:0 and the next pointer in bits 15:8. Its control half (bits 31:16) holds enable at bit 16, the capable log2 at bits 19:17, the granted log2 at bits 22:20, the 64-bit flag at bit 23 and the mask-capable flag at bit 24.
- R2: The window begins at dword CAP_BASE/4. Its length in bytes is 0x0A (32-bit, no masking), 0x0E (64-bit, no masking), 0x14 (32-bit with masking) or 0x18 (64-bit with masking), rounded up to whole dwords. cfg_hit is high only inside the window, and reads outside it return zero. Dword 1 holds the low address. In 64-bit mode dword 2 holds the high address. Data sits at byte offset 0x08 (32-bit) or 0x0C (64-bit), and the mask and pending dwords follow it.
- R3: In the control half only the enable bit and the granted-count field take writes. The ID, the next pointer, the capable field and both option flags never change.
- R4: The low address always reads with bits 1:0 zero. The high address is fully writable when present. The data is a 16-bit field whose upper half reads zero.
- R5: A write changes only the byte lanes whose cfg_be bit is set.
- R6: Mask bits are writable for vectors 0 to 2^CAP_LOG2-1 only. Higher bits read zero.
- R7: When a write into the window leaves the enable bit set and the granted field above the capable field, the granted field is stored as the capable value. With the enable bit clear, no clamp is applied.
- R8: intx_deassert is high for exactly the cycle after a write into the window whose result has the enable bit set. At all other times it is low.
- R9: A write into the window whose result has the enable bit set clears every pending bit at or above 2^granted (the value after R7).
- R10: Software writes to the pending dword have no effect. pend_set sets bits and pend_clr clears them on the next edge, and clear wins when both name a bit. Bits at or above 2^CAP_LOG2 never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dw_addr | input | CFG_AW | Configuration dword address |
| cfg_we | input | 1 | Write strobe, one cycle per write |
| cfg_be | input | 4 | Byte lane enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_hit | output | 1 | Address falls inside the capability window |
| cfg_rdata | output | 32 | Read data, zero outside the window |
| pend_set | input | 32 | Hardware request to set pending bits |
| pend_clr | input | 32 | Hardware request to clear pending bits |
| msi_en | output | 1 | Capability enabled |
| msi_mme | output | 3 | Granted vector count, log2 |
| msi_addr | output | 64 | Message address (upper half zero without 64-bit support) |
| msi_data | output | 16 | Message data |
| vec_mask | output | 32 | Per-vector mask bits |
| vec_pend | output | 32 | Per-vector pending bits |
| intx_deassert | output | 1 | One-cycle request to drop the legacy interrupt |

## Verification
The bench builds two instances side by side. The first has 64-bit addressing, per-vector masking and eight capable vectors. This gives the largest window and lets the mask, pending and trim behaviour with non-trivial vector counts be reached. The second has 32-bit addressing, no masking and two capable vectors. It shows the short window, the data dword moving to offset 0x08, and the clamp acting at a low ceiling. The bench sweeps every granted value 0 to 7 into both instances, every byte-enable pattern over one register, and the address range on both sides of each window. All expected values are computed from the requirement formulas.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

   localparam logic [7:0] MSI_CAP_ID = 8'h05;
   localparam int         MSI_VEC_W  = 32;

   // Capability length in bytes for a given option set
   function automatic int cap_len_bytes(input bit a64, input bit pvm);
      if (pvm) return a64 ? 24 : 20;
      return a64 ? 14 : 10;
   endfunction

   // Dword offset of the message data inside the capability
   function automatic int data_dw_off(input bit a64);
      return a64 ? 3 : 2;
   endfunction

   // Replace the byte lanes selected by be
   function automatic logic [31:0] lane_merge(input logic [31:0] cur,
                                              input logic [31:0] wd,
                                              input logic [3:0]  be);
      logic [31:0] r;
      r = cur;
      for (int i = 0; i < 4; i++) begin
         if (be[i]) r[8*i +: 8] = wd[8*i +: 8];
      end
      return r;
   endfunction

endpackage

// File: rtl/msi_ctl_reg.sv
module msi_ctl_reg #(
   parameter int CAP_LOG2 = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       any_wr,
   input  logic       ctl_wr,
   input  logic [7:0] ctl_byte,
   output logic       en_o,
   output logic [2:0] mme_o,
   output logic       en_next_o,
   output logic [2:0] mme_next_o
);
   localparam logic [2:0] CAP_F = 3'(CAP_LOG2);

   logic       en_q, en_w;
   logic [2:0] mme_q, mme_w;
   logic       clamp;
   logic       ctl_unused;

   assign ctl_unused = ^{ctl_byte[7], ctl_byte[3:1]};

   always_comb begin
      en_w  = ctl_wr ? ctl_byte[0]   : en_q;
      mme_w = ctl_wr ? ctl_byte[6:4] : mme_q;
      clamp = any_wr && en_w && (mme_w > CAP_F);
      en_next_o  = en_w;
      mme_next_o = clamp ? CAP_F : mme_w;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         mme_q <= 3'd0;
      end else begin
         en_q  <= en_next_o;
         mme_q <= mme_next_o;
      end
   end

   assign en_o  = en_q;
   assign mme_o = mme_q;

   // R7
   mme_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |-> (mme_q <= CAP_F));

endmodule

// File: rtl/msi_msg_reg.sv
module msi_msg_reg
   import msi_cap_pkg::*;
#(
   parameter bit ADDR64 = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        lo_wr,
   input  logic        hi_wr,
   input  logic        data_wr,
   input  logic [3:0]  be,
   input  logic [31:0] wdata,
   output logic [63:0] addr_o,
   output logic [15:0] data_o
);
   logic [29:0] lo_q;
   logic [15:0] data_q;
   logic [31:0] lo_full, data_full;
   logic        msg_unused;

   assign lo_full   = lane_merge({lo_q, 2'b00}, wdata, be);
   assign data_full = lane_merge({16'h0000, data_q}, wdata, be);
   assign msg_unused = ^{lo_full[1:0], data_full[31:16]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q   <= '0;
         data_q <= '0;
      end else begin
         if (lo_wr)   lo_q   <= lo_full[31:2];
         if (data_wr) data_q <= data_full[15:0];
      end
   end

   assign addr_o[31:0] = {lo_q, 2'b00};
   assign data_o       = data_q;

   generate
      if (ADDR64) begin : g_hi
         logic [31:0] hi_q;
         always_ff @(posedge clk) begin
            if (!rst_n)     hi_q <= '0;
            else if (hi_wr) hi_q <= lane_merge(hi_q, wdata, be);
         end
         assign addr_o[63:32] = hi_q;
      end else begin : g_no_hi
         logic hi_unused;
         assign hi_unused = hi_wr;
         assign addr_o[63:32] = '0;
      end
   endgenerate

endmodule

// File: rtl/msi_vec_bits.sv
module msi_vec_bits
   import msi_cap_pkg::*;
#(
   parameter bit PVM      = 1'b1,
   parameter int CAP_LOG2 = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        mask_wr,
   input  logic [3:0]  be,
   input  logic [31:0] wdata,
   input  logic        trim,
   input  logic [2:0]  mme_next,
   input  logic [31:0] pend_set,
   input  logic [31:0] pend_clr,
   output logic [31:0] mask_o,
   output logic [31:0] pend_o
);
   localparam int          NCAP     = 1 << CAP_LOG2;
   localparam logic [31:0] CAP_MASK = (NCAP >= MSI_VEC_W) ? 32'hFFFF_FFFF
                                                          : 32'((64'd1 << NCAP) - 64'd1);

   generate
      if (PVM) begin : g_pvm
         logic [31:0] mask_q, pend_q, keep, pend_n;

         always_comb begin
            for (int i = 0; i < MSI_VEC_W; i++) begin
               keep[i] = (i < (1 << int'(mme_next)));
            end
            pend_n = (pend_q | (pend_set & CAP_MASK)) & ~pend_clr;
            if (trim) pend_n = pend_n & keep;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mask_q <= '0;
               pend_q <= '0;
            end else begin
               if (mask_wr) mask_q <= lane_merge(mask_q, wdata, be) & CAP_MASK;
               pend_q <= pend_n;
            end
         end

         assign mask_o = mask_q;
         assign pend_o = pend_q;

         // R10
         pend_no_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_set == '0) |=> ((pend_q & ~$past(pend_q)) == '0));
         // R10
         pend_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_clr != '0) |=> ((pend_q & $past(pend_clr)) == '0));
         // R9
         pend_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
            trim |=> ((pend_q & ~$past(keep)) == '0));
      end else begin : g_no_pvm
         logic vec_unused;
         assign vec_unused = ^{clk, rst_n, mask_wr, be, wdata, trim, mme_next,
                               pend_set, pend_clr};
         assign mask_o = '0;
         assign pend_o = '0;
      end
   endgenerate

endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
   import msi_cap_pkg::*;
#(
   parameter int         CFG_AW   = 10,
   parameter logic [7:0] CAP_BASE = 8'h50,
   parameter logic [7:0] NEXT_PTR = 8'h00,
   parameter bit         ADDR64   = 1'b1,
   parameter bit         PVM      = 1'b1,
   parameter int         CAP_LOG2 = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CFG_AW-1:0] cfg_dw_addr,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_be,
   input  logic [31:0]       cfg_wdata,
   output logic              cfg_hit,
   output logic [31:0]       cfg_rdata,
   input  logic [31:0]       pend_set,
   input  logic [31:0]       pend_clr,
   output logic              msi_en,
   output logic [2:0]        msi_mme,
   output logic [63:0]       msi_addr,
   output logic [15:0]       msi_data,
   output logic [31:0]       vec_mask,
   output logic [31:0]       vec_pend,
   output logic              intx_deassert
);
   localparam int BASE_DW = int'(CAP_BASE) / 4;
   localparam int LEN_B   = cap_len_bytes(ADDR64, PVM);
   localparam int NDW     = (LEN_B + 3) / 4;
   localparam int DATA_DW = data_dw_off(ADDR64);

   localparam logic [CFG_AW-1:0] BASE_A = CFG_AW'(BASE_DW);
   localparam logic [CFG_AW-1:0] NDW_A  = CFG_AW'(NDW);
   localparam logic [CFG_AW-1:0] LO_A   = CFG_AW'(1);
   localparam logic [CFG_AW-1:0] HI_A   = CFG_AW'(2);
   localparam logic [CFG_AW-1:0] DATA_A = CFG_AW'(DATA_DW);
   localparam logic [CFG_AW-1:0] MASK_A = CFG_AW'(DATA_DW + 1);
   localparam logic [CFG_AW-1:0] PEND_A = CFG_AW'(DATA_DW + 2);
   localparam logic [2:0]        CAP_F  = 3'(CAP_LOG2);

   generate
      if (CAP_LOG2 < 0 || CAP_LOG2 > 5) begin : g_bad_cap
         $error("CAP_LOG2 must lie in 0..5");
      end
      if ((CAP_BASE % 4) != 0) begin : g_bad_base
         $error("CAP_BASE must be dword aligned");
      end
      if (BASE_DW + NDW > (1 << CFG_AW)) begin : g_bad_fit
         $error("capability does not fit the configuration space");
      end
   endgenerate

   logic [CFG_AW-1:0] rel;
   logic              wr;
   logic              en_next;
   logic [2:0]        mme_next;
   logic              intx_q;
   logic [15:0]       ctrl;

   assign rel     = cfg_dw_addr - BASE_A;
   assign cfg_hit = (cfg_dw_addr >= BASE_A) && (rel < NDW_A);
   assign wr      = cfg_we && cfg_hit;

   msi_ctl_reg #(.CAP_LOG2(CAP_LOG2)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .any_wr    (wr),
      .ctl_wr    (wr && (rel == '0) && cfg_be[2]),
      .ctl_byte  (cfg_wdata[23:16]),
      .en_o      (msi_en),
      .mme_o     (msi_mme),
      .en_next_o (en_next),
      .mme_next_o(mme_next)
   );

   msi_msg_reg #(.ADDR64(ADDR64)) u_msg (
      .clk    (clk),
      .rst_n  (rst_n),
      .lo_wr  (wr && (rel == LO_A)),
      .hi_wr  (ADDR64 && wr && (rel == HI_A)),
      .data_wr(wr && (rel == DATA_A)),
      .be     (cfg_be),
      .wdata  (cfg_wdata),
      .addr_o (msi_addr),
      .data_o (msi_data)
   );

   msi_vec_bits #(.PVM(PVM), .CAP_LOG2(CAP_LOG2)) u_vec (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask_wr (wr && (rel == MASK_A)),
      .be      (cfg_be),
      .wdata   (cfg_wdata),
      .trim    (wr && en_next),
      .mme_next(mme_next),
      .pend_set(pend_set),
      .pend_clr(pend_clr),
      .mask_o  (vec_mask),
      .pend_o  (vec_pend)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) intx_q <= 1'b0;
      else        intx_q <= wr && en_next;
   end
   assign intx_deassert = intx_q;

   assign ctrl = {7'b0, PVM, ADDR64, msi_mme, CAP_F, msi_en};

   always_comb begin
      cfg_rdata = '0;
      if (cfg_hit) begin
         if (rel == '0)                  cfg_rdata = {ctrl, NEXT_PTR, MSI_CAP_ID};
         else if (rel == LO_A)           cfg_rdata = msi_addr[31:0];
         else if (ADDR64 && rel == HI_A) cfg_rdata = msi_addr[63:32];
         else if (rel == DATA_A)         cfg_rdata = {16'h0000, msi_data};
         else if (PVM && rel == MASK_A)  cfg_rdata = vec_mask;
         else if (PVM && rel == PEND_A)  cfg_rdata = vec_pend;
      end
   end

   // R8
   intx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      intx_deassert |-> ($past(cfg_we && cfg_hit) && msi_en));
   // R2
   rdata_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_hit |-> (cfg_rdata == '0));

endmodule

// File: tb/test_msi_cap_regs.sv
`timescale 1ns/1ps
module test_msi_cap_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  cfg_dw_addr = '0;
   logic        we_a = 1'b0, we_b = 1'b0;
   logic [3:0]  cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] pend_set = '0, pend_clr = '0;

   logic        hit_a, hit_b, en_a, en_b, intx_a, intx_b;
   logic [31:0] rd_a, rd_b, mask_a, mask_b, pend_a, pend_b;
   logic [2:0]  mme_a, mme_b;
   logic [63:0] addr_a, addr_b;
   logic [15:0] data_a, data_b;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   msi_cap_regs #(.CFG_AW(10), .CAP_BASE(8'h50), .NEXT_PTR(8'h78),
                  .ADDR64(1'b1), .PVM(1'b1), .CAP_LOG2(3)) i_msi_cap_regs (
      .clk(clk), .rst_n(rst_n), .cfg_dw_addr(cfg_dw_addr), .cfg_we(we_a),
      .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_hit(hit_a), .cfg_rdata(rd_a),
      .pend_set(pend_set), .pend_clr(pend_clr), .msi_en(en_a), .msi_mme(mme_a),
      .msi_addr(addr_a), .msi_data(data_a), .vec_mask(mask_a), .vec_pend(pend_a),
      .intx_deassert(intx_a));

   msi_cap_regs #(.CFG_AW(10), .CAP_BASE(8'h50), .NEXT_PTR(8'h78),
                  .ADDR64(1'b0), .PVM(1'b0), .CAP_LOG2(1)) i_msi_cap_regs_b (
      .clk(clk), .rst_n(rst_n), .cfg_dw_addr(cfg_dw_addr), .cfg_we(we_b),
      .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_hit(hit_b), .cfg_rdata(rd_b),
      .pend_set(pend_set), .pend_clr(pend_clr), .msi_en(en_b), .msi_mme(mme_b),
      .msi_addr(addr_b), .msi_data(data_b), .vec_mask(mask_b), .vec_pend(pend_b),
      .intx_deassert(intx_b));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic b, input int dw,
                     input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      cfg_dw_addr = 10'(dw); cfg_be = be; cfg_wdata = d; we_a = a; we_b = b;
      @(negedge clk);
      we_a = 1'b0; we_b = 1'b0;
   endtask

   task automatic rd(input int dw);
      cfg_dw_addr = 10'(dw);
      #1;
   endtask

   task automatic pend_pulse(input logic [31:0] s, input logic [31:0] c);
      @(negedge clk);
      pend_set = s; pend_clr = c;
      @(negedge clk);
      pend_set = '0; pend_clr = '0;
   endtask

   function automatic logic [31:0] ctl_a(input int en, input int mme);
      return {7'b0, 1'b1, 1'b1, 3'(mme), 3'd3, 1'(en), 8'h78, 8'h05};
   endfunction
   function automatic logic [31:0] ctl_b(input int en, input int mme);
      return {7'b0, 1'b0, 1'b0, 3'(mme), 3'd1, 1'(en), 8'h78, 8'h05};
   endfunction

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] model;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      rd(20); chk("R1 ctl A", rd_a, ctl_a(0, 0)); chk("R1 ctl B", rd_b, ctl_b(0, 0));
      for (int k = 21; k < 26; k++) begin
         rd(k); chk("R1 dword A", rd_a, 0);
      end
      chk("R1 outputs A", {en_a, mme_a, addr_a, data_a, mask_a, pend_a}, 0);
      chk("R1 outputs B", {en_b, mme_b, addr_b, data_b}, 0);

      // R2 window sweep: A is 6 dwords, B is 3 dwords from dword 20
      for (int k = 16; k < 30; k++) begin
         rd(k);
         chk("R2 hit A", hit_a, (k >= 20 && k < 26));
         chk("R2 hit B", hit_b, (k >= 20 && k < 23));
         if (!(k >= 20 && k < 26)) chk("R2 outside A", rd_a, 0);
         if (!(k >= 20 && k < 23)) chk("R2 outside B", rd_b, 0);
      end

      // R3 read-only control fields, disabled so no clamp
      wr(1, 1, 20, 4'hF, 32'hFFFE_FFFF);
      rd(20);
      chk("R3 ctl A", rd_a, ctl_a(0, 7));
      chk("R3 ctl B", rd_b, ctl_b(0, 7));
      chk("R8 no pulse when disabled", {intx_a, intx_b}, 0);

      // R7 sweep of granted values with enable set
      for (int v = 0; v < 8; v++) begin
         wr(1, 1, 20, 4'b0100, {8'h00, 4'(v), 4'h1, 16'h0000});
         chk("R8 pulse A", intx_a, 1);
         chk("R8 pulse B", intx_b, 1);
         rd(20);
         chk("R7 clamp A", rd_a, ctl_a(1, (v > 3) ? 3 : v));
         chk("R7 clamp B", rd_b, ctl_b(1, (v > 1) ? 1 : v));
         chk("R7 mme out A", mme_a, (v > 3) ? 3 : v);
         @(negedge clk);
         chk("R8 pulse one cycle", {intx_a, intx_b}, 0);
      end
      wr(1, 1, 20, 4'b0100, 32'h0000_0000);
      chk("R8 disabling write", {intx_a, intx_b}, 0);
      chk("R3 enable cleared", {en_a, en_b}, 0);

      // R4 address and data fields; data at 0x0C on A, 0x08 on B (R2)
      wr(1, 0, 21, 4'hF, 32'hFFFF_FFFF);
      wr(1, 0, 22, 4'hF, 32'hDEAD_BEEF);
      wr(1, 0, 23, 4'hF, 32'hFFFF_FFFF);
      rd(21); chk("R4 lo A", rd_a, 32'hFFFF_FFFC);
      rd(23); chk("R2 R4 data A", rd_a, 32'h0000_FFFF);
      chk("R4 addr A", addr_a, 64'hDEAD_BEEF_FFFF_FFFC);
      chk("R4 data out A", data_a, 16'hFFFF);
      wr(0, 1, 21, 4'hF, 32'h1234_5677);
      wr(0, 1, 22, 4'hF, 32'hCAFE_F00D);
      rd(22); chk("R2 R4 data B", rd_b, 32'h0000_F00D);
      chk("R4 addr B", addr_b, 64'h0000_0000_1234_5674);
      chk("R4 data out B", data_b, 16'hF00D);

      // R5 byte-lane sweep on A high address
      model = 32'hDEAD_BEEF;
      for (int b = 0; b < 16; b++) begin
         logic [31:0] d;
         d = 32'h0102_0304 * 32'(b + 3);
         wr(1, 0, 22, 4'(b), d);
         for (int l = 0; l < 4; l++) begin
            if (b[l]) model[8*l +: 8] = d[8*l +: 8];
         end
         rd(22);
         chk("R5 lanes", rd_a, model);
      end
      chk("R5 addr out", addr_a[63:32], model);

      // R6 mask writable range (8 vectors)
      wr(1, 0, 24, 4'hF, 32'hFFFF_FFFF);
      rd(24); chk("R6 mask all", rd_a, 32'h0000_00FF);
      wr(1, 0, 24, 4'b0001, 32'hFFFF_FF5A);
      rd(24); chk("R6 mask lane", rd_a, 32'h0000_005A);
      chk("R6 mask out", mask_a, 32'h0000_005A);

      // R10 pending side port
      pend_pulse(32'hFFFF_FFFF, 32'h0);
      rd(25); chk("R10 set limited", rd_a, 32'h0000_00FF);
      chk("R10 no pending B", pend_b, 0);
      wr(1, 0, 25, 4'hF, 32'h0000_0000);
      rd(25); chk("R10 sw write ignored", rd_a, 32'h0000_00FF);
      pend_pulse(32'h0000_000F, 32'h0000_0003);
      chk("R10 clear wins", pend_a, 32'h0000_00FC);
      pend_pulse(32'h0, 32'h0000_00FF);
      chk("R10 clear all", pend_a, 0);

      // R9 trim on enabled write
      pend_pulse(32'h0000_00FF, 32'h0);
      wr(1, 0, 20, 4'b0100, 32'h0011_0000);
      chk("R8 pulse enable", intx_a, 1);
      chk("R9 trim to 2", pend_a, 32'h0000_0003);
      pend_pulse(32'h0000_00F0, 32'h0);
      chk("R9 set after trim", pend_a, 32'h0000_00F3);
      wr(1, 0, 24, 4'b0001, 32'h0000_0000);
      chk("R9 trim on mask write", pend_a, 32'h0000_0003);
      chk("R8 pulse mask write", intx_a, 1);
      wr(1, 0, 20, 4'b0100, 32'h0001_0000);
      chk("R9 trim to 1", pend_a, 32'h0000_0001);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule